// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Receiver

This block is the serial front end of a peripheral that is programmed with 16-bit command words over a four-wire link. The link has a serial clock, a data input, an active-low select and a data output. The block samples all three inputs in its own faster system clock domain and finds the serial clock and select edges there. While select is low it shifts data in, most significant bit first. When select returns high it latches the word and decodes it. A completed write command becomes a single system-clock write strobe carrying a register address and a data byte. No-op words and words that are not writes produce no strobe.

The data output repeats the input stream half a serial clock behind the sixteenth bit. Because of this, several receivers can share one select and one serial clock in a chain, with each output wired to the next input. An access to a chain of n receivers takes 16·n serial clocks. After reset the output is low, so a downstream receiver that has not yet been reached only ever shifts in zeros, and sixteen zeros decode as a no-op.

The control sequence is a five-state machine. IDLE waits for select low and then takes the *open* transition to SHIFT. SHIFT waits for select to rise, then takes the *capture* transition to LATCH, which stores the word and its bit count. LATCH always takes the *evaluate* transition to DECODE. DECODE takes the *accept* transition to WRITE for a valid write, or the *reject* transition back to IDLE. WRITE raises the strobe for one cycle and takes the *retire* transition back to IDLE.

Top module: `serial_cmd_rx`

## Requirements
- R1: A command word is 16 bits, sent most significant bit first. Bits 15..8 are the address byte and bits 7..0 are the data byte. A write presents wr_addr_o = bits 14..8 and wr_data_o = bits 7..0.
- R2: While cs_n_i is low, one bit of din_i is shifted in on each rising edge of sclk_i.
- R3: While cs_n_i is high, sclk_i transitions have no effect: the shift register and dout_o do not change.
- R4: On a rising edge of cs_n_i the shifted word is latched and decoded. A valid write then raises wr_en_o for exactly one clk cycle, with the address and data valid during that cycle.
- R5: A word whose bit 15 is 1 is not a write and produces no strobe.
- R6: A word whose address byte is 0x00 is a no-op, and this includes the all-zero word. It produces no strobe.
- R7: dout_o is updated from the top bit of the shift register on each falling edge of sclk_i while cs_n_i is low. A bit therefore appears on dout_o 15.5 serial clocks after it entered.
- R8: After reset, wr_en_o and dout_o are low, and the shift register holds zeros. A downstream device therefore receives only zeros until the first full word has passed.
- R9: If the number of rising sclk_i edges between the fall and the rise of cs_n_i is not 16, the word is discarded and no strobe is issued.
- R10: When the rise of cs_n_i and a fall of sclk_i reach the system clock in the same sample, the word is still latched and executed, and dout_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than sclk_i |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| din_i | input | 1 | Serial data in, MSB first |
| cs_n_i | input | 1 | Active-low select; its rise latches the word |
| dout_o | output | 1 | Serial data out to the next device in the chain |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register address, word bits 14..8 |
| wr_data_o | output | 8 | Register data, word bits 7..0 |

## Verification
Two functions can fall into the same system-clock sample: latching a finished word when select rises, and the serial clock fall that would normally move the chain output. The bench provokes this in alternate table frames by raising select and lowering the serial clock on the same system clock edge. The other frames follow the usual order, where select rises while the clock is still high. In both kinds of frame the bench requires exactly one strobe with the right fields, and requires that the chain output keep the value it had before select rose.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LATCH,
        ST_DECODE,
        ST_WRITE
    } scr_state_e;

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL[g]}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[g]};
                end
            end

            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/scr_edge.sv
module scr_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= level_i;
        end
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_det
            assign rise_o[g] =  level_i[g] & ~prev_q[g];
            assign fall_o[g] = ~level_i[g] &  prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_i,
    input  logic              cs_n_i,
    input  logic              cs_fall_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              dout_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [WORD_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dout_q;
    logic              shift_en;
    logic              out_en;
    logic [CNT_W-1:0]  cnt_inc;

    assign shift_en = sclk_rise_i & ~cs_n_i;
    assign out_en   = sclk_fall_i & ~cs_n_i;
    assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sr_q  <= {sr_q[WORD_W-2:0], din_i};
            cnt_q <= cs_fall_i ? CNT_W'(1) : cnt_inc;
        end else if (cs_fall_i) begin
            cnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (out_en) begin
            dout_q <= sr_q[WORD_W-1];
        end
    end

    assign word_o  = sr_q;
    assign count_o = cnt_q;
    assign dout_o  = dout_q;

    AST_SR_HOLD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> $stable(sr_q)) else $error("shift register moved with select high"); // R3

    AST_DOUT_HOLD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> $stable(dout_q)) else $error("chain output moved with select high"); // R3

    AST_CNT_CLEAR_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall_i && !sclk_rise_i) |=> (cnt_q == '0)) else $error("bit count not cleared"); // R9

endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
    import scr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              cs_rise_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              wr_en_o,
    output logic [WORD_W-DATA_W-2:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam int SEL_W  = WORD_W - DATA_W;
    localparam int ADDR_W = SEL_W - 1;

    scr_state_e        state_q;
    scr_state_e        state_d;
    logic [WORD_W-1:0] word_q;
    logic              len_ok_q;
    logic              accept;

    // Decode of the latched word: full length, write flag clear, non-zero address byte
    assign accept = len_ok_q
                  & ~word_q[WORD_W-1]
                  & (word_q[WORD_W-1:DATA_W] != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!cs_n_i)   state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise_i) state_d = ST_LATCH;
            ST_LATCH:                 state_d = ST_DECODE;
            ST_DECODE: state_d = accept ? ST_WRITE : ST_IDLE;
            ST_WRITE:                 state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            len_ok_q <= 1'b0;
        end else if (state_q == ST_SHIFT && cs_rise_i) begin
            word_q   <= word_i;
            len_ok_q <= (count_i == CNT_W'(WORD_W));
        end
    end

    always_comb begin
        wr_en_o   = 1'b0;
        wr_addr_o = word_q[DATA_W +: ADDR_W];
        wr_data_o = word_q[DATA_W-1:0];
        unique case (state_q)
            ST_WRITE: wr_en_o = 1'b1;
            ST_IDLE, ST_SHIFT, ST_LATCH, ST_DECODE: wr_en_o = 1'b0;
            default:  wr_en_o = 1'b0;
        endcase
    end

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o) else $error("write strobe longer than one cycle"); // R4

    AST_WR_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> len_ok_q) else $error("strobe for a short or long word"); // R9

    AST_WR_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> $stable(word_q)) else $error("latched word moved before strobe"); // R4

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
    parameter int WORD_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_i,
    input  logic                       din_i,
    input  logic                       cs_n_i,
    output logic                       dout_o,
    output logic                       wr_en_o,
    output logic [WORD_W-DATA_W-2:0]   wr_addr_o,
    output logic [DATA_W-1:0]          wr_data_o
);

    localparam int ADDR_W = WORD_W - DATA_W - 1;
    localparam int CNT_W  = $clog2(WORD_W + 1) + 1;

    // Synchronized vector: bit 2 = select, bit 1 = data, bit 0 = serial clock
    logic [2:0] sync_lvl;
    logic [1:0] edge_rise;
    logic [1:0] edge_fall;
    logic [WORD_W-1:0] sh_word;
    logic [CNT_W-1:0]  sh_count;

    scr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, din_i, sclk_i}),
        .sync_o  (sync_lvl)
    );

    // Edge vector: bit 1 = select, bit 0 = serial clock
    scr_edge #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({sync_lvl[2], sync_lvl[0]}),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    scr_shifter #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) i_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .din_i       (sync_lvl[1]),
        .cs_n_i      (sync_lvl[2]),
        .cs_fall_i   (edge_fall[1]),
        .sclk_rise_i (edge_rise[0]),
        .sclk_fall_i (edge_fall[0]),
        .word_o      (sh_word),
        .count_o     (sh_count),
        .dout_o      (dout_o)
    );

    scr_ctrl #(
        .WORD_W (WORD_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (sync_lvl[2]),
        .cs_rise_i (edge_rise[1]),
        .word_i    (sh_word),
        .count_i   (sh_count),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    AST_WR_ADDR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o != '0)) else $error("strobe for a no-op address"); // R6

    AST_WR_ONLY_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> sync_lvl[2]) else $error("strobe while select still low"); // R4

    initial begin
        assert (ADDR_W >= 1) else $error("address field too narrow"); // R1
    end

endmodule

// File: tb/test_serial_cmd_rx.sv
`timescale 1ns/1ps
module test_serial_cmd_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       cs_n = 1'b1;
    logic       dout;
    logic       wr_en;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cycles = 0;
    logic [6:0] cap_addr = '0;
    logic [7:0] cap_data = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_cmd_rx i_serial_cmd_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .din_i     (din),
        .cs_n_i    (cs_n),
        .dout_o    (dout),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            wr_cycles <= wr_cycles + 1;
            cap_addr  <= wr_addr;
            cap_data  <= wr_data;
        end
    end

    localparam int NV = 8;
    localparam logic [15:0] VEC_WORD [NV] = '{
        16'h0000, 16'h0155, 16'h7FA3, 16'h8123,
        16'h00FF, 16'h2A00, 16'hFFFF, 16'h5AC3
    };
    localparam logic VEC_WR [NV] = '{
        1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits of w (MSB first). If chk_out, checks dout against prev after each in-frame fall.
    // simul=1 raises select and lowers sclk on the same edge.
    task automatic send_frame(input logic [31:0] w, input int nbits, input bit chk_out,
                              input logic [15:0] prev, input bit simul);
        logic held;
        wr_cycles = 0;
        sclk = 1'b0;
        cs_n = 1'b0;
        wclk(8);
        for (int i = 0; i < nbits; i++) begin
            din = w[nbits-1-i];
            wclk(4);
            sclk = 1'b1;
            wclk(8);
            if (i < nbits - 1) begin
                sclk = 1'b0;
                wclk(6);
                if (chk_out && i <= 14)
                    chk(dout == prev[14-i], "R7 dout chain latency", 32'(dout), 32'(prev[14-i]));
            end
        end
        held = dout;
        if (simul) begin
            cs_n = 1'b1;
            sclk = 1'b0;
            wclk(16);
        end else begin
            cs_n = 1'b1;
            wclk(8);
            sclk = 1'b0;
            wclk(16);
        end
        if (chk_out)
            chk(dout == held, "R10 dout holds at select rise", 32'(dout), 32'(held));
    endtask

    initial begin
        logic [15:0] prev;
        logic [15:0] stored;
        wclk(3);
        chk(wr_en == 1'b0, "R8 reset strobe low", 32'(wr_en), 0);
        chk(dout == 1'b0, "R8 reset dout low", 32'(dout), 0);
        rst_n = 1'b1;
        wclk(4);
        chk(dout == 1'b0, "R8 dout low after reset", 32'(dout), 0);

        // Table walk: prev starts at zero, so the first frame also checks R8 zeros downstream
        prev = 16'h0000;
        for (int v = 0; v < NV; v++) begin
            send_frame(32'(VEC_WORD[v]), 16, 1'b1, prev, v[0]);
            chk(wr_cycles == (VEC_WR[v] ? 1 : 0), "R4 R5 R6 strobe count",
                32'(wr_cycles), VEC_WR[v] ? 1 : 0);
            if (VEC_WR[v]) begin
                chk(cap_addr == VEC_WORD[v][14:8], "R1 address field", 32'(cap_addr), 32'(VEC_WORD[v][14:8]));
                chk(cap_data == VEC_WORD[v][7:0], "R1 R2 data field", 32'(cap_data), 32'(VEC_WORD[v][7:0]));
            end
            prev = VEC_WORD[v];
        end

        // R3: sclk toggling with select high must not shift or move dout
        stored = prev;
        begin
            logic d0;
            d0 = dout;
            for (int k = 0; k < 5; k++) begin
                din = k[0];
                sclk = 1'b1; wclk(8);
                sclk = 1'b0; wclk(8);
                chk(dout == d0, "R3 dout with select high", 32'(dout), 32'(d0));
            end
        end
        send_frame(32'h0000_1234, 16, 1'b1, stored, 1'b0);
        chk(wr_cycles == 1, "R3 frame after idle toggles", 32'(wr_cycles), 1);
        chk(cap_data == 8'h34, "R3 data after idle toggles", 32'(cap_data), 32'h34);

        // R9: wrong bit counts are discarded
        send_frame(32'h0000_3C3C >> 1, 15, 1'b0, '0, 1'b0);
        chk(wr_cycles == 0, "R9 fifteen bits discarded", 32'(wr_cycles), 0);
        send_frame(32'h0001_0155, 17, 1'b0, '0, 1'b0);
        chk(wr_cycles == 0, "R9 seventeen bits discarded", 32'(wr_cycles), 0);
        send_frame(32'h0000_0666, 16, 1'b0, '0, 1'b1);
        chk(wr_cycles == 1, "R9 full word after discard", 32'(wr_cycles), 1);
        chk(cap_addr == 7'h06 && cap_data == 8'h66, "R1 fields after discard",
            {17'd0, cap_addr, cap_data}, 32'h0666);

        // R8: reset mid-stream returns dout low
        rst_n = 1'b0;
        wclk(2);
        chk(dout == 1'b0, "R8 dout low in reset", 32'(dout), 0);
        rst_n = 1'b1;
        wclk(4);
        send_frame(32'h0000_0000, 16, 1'b1, 16'h0000, 1'b0);
        chk(wr_cycles == 0, "R6 all-zero no-op after reset", 32'(wr_cycles), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R4 actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule